// File: doc/BRIEF.md
# Constant-Fraction Gated Dual Charge Integrator

This block holds one captured record of baseline-corrected detector samples. Given the pulse peak value and the peak index, it produces two charge integrals for pulse-shape discrimination: a short one and a long one. A constant-fraction threshold of one quarter of the peak value locates the leading edge of the pulse. Both integration windows are measured from that crossing point and not from a fixed index.

The record is loaded through a write port that takes an index and a value. A start command then carries the peak value and the peak index. The block runs two scans. The first scan walks from index 16 up to the peak. It moves the crossing index forward for every sample that is below the threshold. If the crossing index is already behind the scan position, a sub-threshold sample is added after the anchor sample's value is subtracted from it. A sample at or above the threshold is added to each integral only while it lies inside that integral's window. The second scan walks from the peak to the end of the longer window. When it completes, a one-cycle done strobe marks valid results: both integrals and the final crossing index.

Forming the ratio of the two integrals, the particle decision and any baseline filtering are left to the blocks around this one.

Top module: `cfd_dual_integrator`

## Requirements
- R1: A sample counts as below threshold when four times its signed value is strictly less than the signed peak value. This is the same test as value < 0.25 × peak, with no rounding.
- R2: The crossing index starts at 16, and the first scan covers indices 16 up to peak index − 1. Each below-threshold sample in that scan raises the crossing index by one. When the peak index is 16 or less, the first scan is empty and the crossing index reported is 16.
- R3: In the first scan, take a below-threshold sample whose index is greater than the current crossing index. Its value, minus the stored sample at that crossing index, is added to both integrals.
- R4: In the first scan, a sample at or above the threshold is added to the short integral only if its index is less than crossing index + 24. It is added to the long integral only if its index is less than crossing index + 270.
- R5: The second scan covers indices from the peak index up to, but not including, the larger of crossing index + 24 and crossing index + 270. Each sample is added to the short integral if its index is less than crossing index + 24, and to the long integral if its index is less than crossing index + 270.
- R6: The record holds indices 0 to 501. A read of any index of 502 or more yields zero, and a write to such an index is discarded.
- R7: While busy is high, a start command is ignored and sample writes are discarded.
- R8: After an accepted start, busy rises on the next cycle. done is high for exactly one cycle, with busy still high. busy is low on the following cycle. The integrals and the crossing index stay on the outputs until the next accepted start.
- R9: After reset, done and busy are low and both integrals read zero.
- R10: The integrals are signed two's-complement values wide enough to hold 270 full-scale positive samples (270 × 32767) without wrapping.

Port widths below use the default parameters: 16-bit samples, 512 stored entries and 26-bit integrals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Sample write strobe |
| wr_idx | input | 9 | Sample index to write |
| wr_data | input | 16 | Signed sample value |
| start | input | 1 | Start command, one cycle |
| peak_val | input | 16 | Signed pulse peak value, captured on an accepted start |
| peak_idx | input | 9 | Pulse peak index, captured on an accepted start |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle strobe that marks valid results |
| short_sum | output | 26 | Signed short-window integral |
| long_sum | output | 26 | Signed long-window integral |
| cross_idx | output | 10 | Final constant-fraction crossing index |

## Verification
Results are checked on the falling edge at which done is first seen high. The bench does not predict a fixed latency for that edge: the scan length depends on the data, since each sub-threshold sample after the anchor costs one extra read cycle. The bench therefore polls done on each falling edge, with a per-case limit. It checks busy one falling edge after start, and it checks that done and busy are both low one falling edge after done. A start command and a sample write are issued a few cycles into a scan. The result of that scan, and the result of a later repeat run on the untouched record, must both match the values the bench computes from the original record.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S1_RD,
    ST_S1_EV,
    ST_S1_AN,
    ST_S2_INIT,
    ST_S2_RD,
    ST_S2_EV,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/cfd_rst_sync.sv
module cfd_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/cfd_sample_ram.sv
module cfd_sample_ram #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 512,
  parameter int REC_LEN = 502,
  parameter int IDX_W   = 10,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_idx,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [DATA_W-1:0] rd_data
);

  localparam logic [IDX_W-1:0] REC_END = IDX_W'(REC_LEN);

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic wr_ok;
  logic rd_ok;

  assign wr_ok = wr_en && (IDX_W'(wr_idx) < REC_END);
  assign rd_ok = rd_idx < REC_END;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= rd_ok ? mem[rd_idx[ADDR_W-1:0]] : '0;
  end

endmodule

// File: rtl/cfd_window_acc.sv
module cfd_window_acc #(
  parameter int VAL_W = 17,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add,
  input  logic signed [VAL_W-1:0] val,
  output logic signed [ACC_W-1:0] sum
);

  logic signed [ACC_W-1:0] sum_d;
  logic                    sum_en;

  always_comb begin
    sum_en = clr | add;
    sum_d  = clr ? '0 : sum + ACC_W'(val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (sum_en) sum <= sum_d;
  end

endmodule

// File: rtl/cfd_scan_seq.sv
module cfd_scan_seq
  import cfd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 10,
  parameter int CFD_START = 16,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 270
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] peak_val,
  input  logic [IDX_W-1:0]         peak_idx,
  input  logic signed [DATA_W-1:0] rd_data,
  output logic                     rd_en,
  output logic [IDX_W-1:0]         rd_idx,
  output logic                     clr,
  output logic                     add_short,
  output logic                     add_long,
  output logic signed [DATA_W:0]   add_val,
  output logic [IDX_W-1:0]         cross_idx,
  output logic                     busy,
  output logic                     done
);

  localparam logic [IDX_W-1:0] START_I = IDX_W'(CFD_START);
  localparam logic [IDX_W-1:0] SHORT_I = IDX_W'(SHORT_LEN);
  localparam logic [IDX_W-1:0] LONG_I  = IDX_W'(LONG_LEN);

  scan_state_e              state_q, state_d;
  logic [IDX_W-1:0]         cur_q, cur_d, cfd_q, cfd_d, pk_idx_q, pk_idx_d;
  logic signed [DATA_W-1:0] pk_val_q, pk_val_d, hold_q, hold_d;

  logic [IDX_W-1:0]         short_end, long_end, scan_end, cur_nx;
  logic signed [DATA_W+1:0] four_v, pk_ext;
  logic                     below;

  always_comb begin
    short_end = cfd_q + SHORT_I;
    long_end  = cfd_q + LONG_I;
    scan_end  = (long_end > short_end) ? long_end : short_end;
    cur_nx    = cur_q + 1'b1;
    four_v    = {rd_data, 2'b00};
    pk_ext    = (DATA_W+2)'(pk_val_q);
    below     = four_v < pk_ext;
  end

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    cfd_d     = cfd_q;
    pk_idx_d  = pk_idx_q;
    pk_val_d  = pk_val_q;
    hold_d    = hold_q;
    rd_en     = 1'b0;
    rd_idx    = cur_q;
    clr       = 1'b0;
    add_short = 1'b0;
    add_long  = 1'b0;
    add_val   = (DATA_W+1)'(rd_data);
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          clr      = 1'b1;
          pk_val_d = peak_val;
          pk_idx_d = peak_idx;
          cur_d    = START_I;
          cfd_d    = START_I;
          state_d  = (peak_idx > START_I) ? ST_S1_RD : ST_S2_INIT;
        end
      end
      ST_S1_RD: begin
        rd_en   = 1'b1;
        state_d = ST_S1_EV;
      end
      ST_S1_EV: begin
        if (below && (cfd_q < cur_q)) begin
          hold_d  = rd_data;
          rd_en   = 1'b1;
          rd_idx  = cfd_q;
          state_d = ST_S1_AN;
        end else begin
          if (below) begin
            cfd_d = cfd_q + 1'b1;
          end else begin
            add_short = cur_q < short_end;
            add_long  = cur_q < long_end;
          end
          cur_d   = cur_nx;
          state_d = (cur_nx < pk_idx_q) ? ST_S1_RD : ST_S2_INIT;
        end
      end
      ST_S1_AN: begin
        add_val   = (DATA_W+1)'(hold_q) - (DATA_W+1)'(rd_data);
        add_short = 1'b1;
        add_long  = 1'b1;
        cfd_d     = cfd_q + 1'b1;
        cur_d     = cur_nx;
        state_d   = (cur_nx < pk_idx_q) ? ST_S1_RD : ST_S2_INIT;
      end
      ST_S2_INIT: begin
        cur_d   = pk_idx_q;
        state_d = (pk_idx_q < scan_end) ? ST_S2_RD : ST_DONE;
      end
      ST_S2_RD: begin
        rd_en   = 1'b1;
        state_d = ST_S2_EV;
      end
      ST_S2_EV: begin
        add_short = cur_q < short_end;
        add_long  = cur_q < long_end;
        cur_d     = cur_nx;
        state_d   = (cur_nx < scan_end) ? ST_S2_RD : ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      cfd_q    <= '0;
      pk_idx_q <= '0;
      pk_val_q <= '0;
      hold_q   <= '0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      cfd_q    <= cfd_d;
      pk_idx_q <= pk_idx_d;
      pk_val_q <= pk_val_d;
      hold_q   <= hold_d;
    end
  end

  assign busy      = state_q != ST_IDLE;
  assign done      = state_q == ST_DONE;
  assign cross_idx = cfd_q;

endmodule

// File: rtl/cfd_dual_integrator.sv
module cfd_dual_integrator #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 512,
  parameter int REC_LEN   = 502,
  parameter int CFD_START = 16,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 270,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int IDX_W    = ADDR_W + 1,
  localparam int ACC_W    = DATA_W + 1 + ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_idx,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] peak_val,
  input  logic [ADDR_W-1:0]        peak_idx,
  output logic                     busy,
  output logic                     done,
  output logic signed [ACC_W-1:0]  short_sum,
  output logic signed [ACC_W-1:0]  long_sum,
  output logic [IDX_W-1:0]         cross_idx
);

  logic                     rst_n_s;
  logic                     rd_en, clr, add_short, add_long;
  logic [IDX_W-1:0]         rd_idx;
  logic signed [DATA_W-1:0] rd_data;
  logic signed [DATA_W:0]   add_val;
  logic [1:0]               add_vec;
  logic signed [ACC_W-1:0]  sums [2];

  cfd_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  cfd_sample_ram #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .REC_LEN (REC_LEN), .IDX_W (IDX_W)
  ) u_ram (
    .clk     (clk),
    .wr_en   (wr_en & ~busy),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  cfd_scan_seq #(
    .DATA_W (DATA_W), .IDX_W (IDX_W), .CFD_START (CFD_START),
    .SHORT_LEN (SHORT_LEN), .LONG_LEN (LONG_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .peak_val  (peak_val),
    .peak_idx  (IDX_W'(peak_idx)),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .clr       (clr),
    .add_short (add_short),
    .add_long  (add_long),
    .add_val   (add_val),
    .cross_idx (cross_idx),
    .busy      (busy),
    .done      (done)
  );

  assign add_vec = {add_long, add_short};

  for (genvar w = 0; w < 2; w++) begin : g_win
    cfd_window_acc #(.VAL_W (DATA_W + 1), .ACC_W (ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (clr),
      .add   (add_vec[w]),
      .val   (add_val),
      .sum   (sums[w])
    );
  end

  assign short_sum = sums[0];
  assign long_sum  = sums[1];

endmodule

// File: rtl/cfd_dual_integrator_chk.sv
module cfd_dual_integrator_chk #(
  parameter int IDX_W     = 10,
  parameter int CFD_START = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] cross_idx
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_busy_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_cross_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cross_idx >= IDX_W'(CFD_START)));

  assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && $past(rst_n) && $past(rst_n, 2)) |=> busy);

endmodule

bind cfd_dual_integrator cfd_dual_integrator_chk #(
  .IDX_W (IDX_W), .CFD_START (CFD_START)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cross_idx (cross_idx)
);

// File: tb/cfd_dual_integrator_tb.sv
`timescale 1ns/1ps
module cfd_dual_integrator_tb;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [8:0]         wr_idx;
  logic signed [15:0] wr_data;
  logic               start;
  logic signed [15:0] peak_val;
  logic [8:0]         peak_idx;
  logic               busy, done;
  logic signed [25:0] short_sum, long_sum;
  logic [9:0]         cross_idx;

  int n_chk  = 0;
  int n_fail = 0;

  int ref_mem [512];
  longint exp_s, exp_l, exp_x;

  always #4 clk = ~clk;

  cfd_dual_integrator u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
    .wr_data (wr_data), .start (start), .peak_val (peak_val),
    .peak_idx (peak_idx), .busy (busy), .done (done),
    .short_sum (short_sum), .long_sum (long_sum), .cross_idx (cross_idx)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rd(int i);
    return (i < 502) ? longint'(ref_mem[i]) : 0;
  endfunction

  function automatic void model(int pv, int pk);
    longint s = 0, l = 0, d;
    int cf = 16;
    for (int i = 16; i < pk; i++) begin
      if (4 * rd(i) < pv) begin
        if (cf < i) begin
          d = rd(i) - rd(cf);
          s += d;
          l += d;
        end
        cf++;
      end else begin
        if (i < cf + 24)  s += rd(i);
        if (i < cf + 270) l += rd(i);
      end
    end
    for (int i = pk; i < cf + 270; i++) begin
      if (i < cf + 24) s += rd(i);
      l += rd(i);
    end
    exp_s = s;
    exp_l = l;
    exp_x = cf;
  endfunction

  function automatic int noise(int i);
    return (i * 37) % 11 - 5;
  endfunction

  function automatic int gen(int kind, int i);
    case (kind)
      0: return (i < 120) ? 20 + noise(i) : (i < 130) ? 300 * (i - 119)
                : 3000 / (1 << (((i - 130) / 20) > 20 ? 20 : (i - 130) / 20));
      1: return (i == 40) ? 2000 : (i < 200) ? noise(i) : (i < 210) ? 400 * (i - 199)
                : 4000 / (1 << (((i - 210) / 16) > 20 ? 20 : (i - 210) / 16));
      2: return (i < 470) ? 10 + noise(i) : (i < 480) ? 200 * (i - 469)
                : 2000 / (1 << (((i - 480) / 4) > 20 ? 20 : (i - 480) / 4));
      3: return 32767;
      default: return -60 + noise(i);
    endcase
  endfunction

  task automatic load(int kind);
    for (int i = 0; i < 502; i++) begin
      ref_mem[i] = gen(kind, i);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_idx  = 9'(i);
      wr_data = 16'(ref_mem[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick(int pv, int pk);
    @(negedge clk);
    start    = 1'b1;
    peak_val = 16'(pv);
    peak_idx = 9'(pk);
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", longint'(busy), 1);
  endtask

  task automatic finish_case(string tag);
    bit seen = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (!seen) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 %s done timeout actual=0 expected=1", tag);
      return;
    end
    chk({tag, " short R4 R5"}, longint'(short_sum), exp_s);
    chk({tag, " long R4 R5"},  longint'(long_sum),  exp_l);
    chk({tag, " cross R2"},    longint'(cross_idx), exp_x);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, longint'(done), 0);
    chk({tag, " R8 idle after"},     longint'(busy), 0);
    chk({tag, " R8 short held"},     longint'(short_sum), exp_s);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    start = 1'b0; peak_val = '0; peak_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 done reset", longint'(done), 0);
    chk("R9 busy reset", longint'(busy), 0);
    chk("R9 short reset", longint'(short_sum), 0);
    chk("R9 long reset", longint'(long_sum), 0);

    // R1 R4 R5: clean pulse, crossing at the rising edge
    load(0);
    model(3000, 130);
    kick(3000, 130);
    finish_case("caseA");

    // R7: start and write during a scan are ignored
    kick(3000, 130);
    repeat (3) @(negedge clk);
    start = 1'b1; peak_val = 16'sd5; peak_idx = 9'd10;
    wr_en = 1'b1; wr_idx = 9'd130; wr_data = 16'sd0;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    finish_case("caseA R7 busy start");
    kick(3000, 130);
    finish_case("caseA R7 write dropped");

    // R3: spike before the pulse makes later noise anchor-subtracted
    load(1);
    model(4000, 210);
    kick(4000, 210);
    finish_case("caseB R3");

    // R2: peak index below start, first scan empty
    load(0);
    model(3000, 10);
    kick(3000, 10);
    finish_case("caseC R2 empty");

    // R6: windows past the record read zero; stray write at 505 dropped
    load(2);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 9'd505; wr_data = 16'sd999;
    @(negedge clk);
    wr_en = 1'b0;
    model(2000, 480);
    kick(2000, 480);
    finish_case("caseD R6");

    // R10: full-scale record
    load(3);
    model(32767, 20);
    kick(32767, 20);
    finish_case("caseE R10");
    chk("R10 long full-scale", longint'(long_sum), 270 * 32767);

    // R1: negative record and peak, every sample below threshold
    load(4);
    model(-100, 300);
    kick(-100, 300);
    finish_case("caseF R1 negative");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule